// File: doc/BRIEF.md
# High-Word Signed Multiply with Optional Rounding

This unit takes two signed 32-bit operands and returns only the upper 32 bits of their 64-bit product. It has three forms. The plain form returns the product's high word. The accumulating form first adds the product to a 64-bit value whose upper word is the accumulator and whose lower word is zero. The subtracting form subtracts the product from that same value. When rounding is requested, bit 31 of the 64-bit value is added into the returned word, so the result is rounded to nearest rather than truncated.

The caller supplies the operation code, the round bit, the register indices it fetched the operands from, and the operand values. The unit checks the indices for the reserved value 15 and flags any bad encoding as unpredictable. Results come out one cycle after a valid input. The unit keeps no condition or saturation state.

Top module: `msw_mul_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `out_result` and `out_unpred` are all 0.
- R2: Op code 3'b101 with accumulator index 15 returns bits [63:32] of the signed 64-bit product of `in_srca` and `in_srcb`.
- R3: Op code 3'b101 with accumulator index 0 to 14 returns bits [63:32] of ({in_acc, 32'h0} + product), computed modulo 2^64.
- R4: Op code 3'b110 returns bits [63:32] of ({in_acc, 32'h0} − product), computed modulo 2^64.
- R5: When `in_round` is 1, bit 31 of the 64-bit value is added to the returned word, wrapping modulo 2^32. For example, 0xFFFFFFFF plus 1 gives 0.
- R6: An index of 15 in `in_dst_idx`, `in_srca_idx` or `in_srcb_idx` sets `out_unpred`. So does accumulator index 15 under op code 3'b110. In either case `out_result` is 0.
- R7: Any op code other than 3'b101 or 3'b110 sets `out_unpred` and forces `out_result` to 0.
- R8: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high. In that cycle it carries the result of that input.
- R9: While `out_valid` is 0, `out_result` and `out_unpred` keep their previous values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operation present |
| in_op | input | 3 | Op code: 3'b101 multiply/accumulate, 3'b110 subtract |
| in_round | input | 1 | Round to nearest when 1 |
| in_dst_idx | input | 4 | Destination register index |
| in_srca_idx | input | 4 | First operand register index |
| in_srcb_idx | input | 4 | Second operand register index |
| in_acc_idx | input | 4 | Accumulator register index; 15 selects plain multiply under 3'b101 |
| in_srca | input | 32 | First signed operand |
| in_srcb | input | 32 | Second signed operand |
| in_acc | input | 32 | Accumulator, placed in the upper word |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Returned high word |
| out_unpred | output | 1 | Unpredictable encoding detected |

## Verification
A wrong decode of the mode shows at the ports as a result off by the whole accumulator. It also shows as a flag that disagrees with the index fields. Either appears in the very cycle `out_valid` rises after the offending input. A wrong rounding carry shows as a result off by exactly one, but only when bit 31 of the 64-bit value is set. Because of that, the extreme operand pairs and a wrap case are driven directly rather than left to chance. A pipeline register that is not held shows as a result that changes while `out_valid` is low. That change can be seen one cycle after the idle input.

// File: rtl/msw_pkg.sv
package msw_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = 4;
    localparam int OP_W   = 3;
    localparam int WIDE_W = 2 * WORD_W;

    localparam logic [OP_W-1:0]  OPC_MULACC   = 3'b101;
    localparam logic [OP_W-1:0]  OPC_MULSUB   = 3'b110;
    localparam logic [IDX_W-1:0] IDX_RESERVED = '1;

    typedef enum logic [1:0] {
        K_MUL = 2'd0,
        K_ACC = 2'd1,
        K_SUB = 2'd2,
        K_BAD = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  round;
        logic  unpred;
    } ctl_t;

    typedef struct packed {
        logic              unpred;
        logic [WORD_W-1:0] word;
    } res_t;

    function automatic logic idx_reserved(input logic [IDX_W-1:0] idx);
        return idx == IDX_RESERVED;
    endfunction

endpackage

// File: rtl/msw_decode.sv
module msw_decode
    import msw_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic             round,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] srca_idx,
    input  logic [IDX_W-1:0] srcb_idx,
    input  logic [IDX_W-1:0] acc_idx,
    output ctl_t             ctl
);

    logic core_bad;

    // Destination and both sources are used by every form.
    assign core_bad = idx_reserved(dst_idx) | idx_reserved(srca_idx) | idx_reserved(srcb_idx);

    always_comb begin
        ctl.round  = round;
        ctl.kind   = K_BAD;
        ctl.unpred = 1'b1;
        unique case (op)
            OPC_MULACC: begin
                // Accumulator field at 15 means the non-accumulating form.
                ctl.kind   = idx_reserved(acc_idx) ? K_MUL : K_ACC;
                ctl.unpred = core_bad;
            end
            OPC_MULSUB: begin
                ctl.kind   = K_SUB;
                ctl.unpred = core_bad | idx_reserved(acc_idx);
            end
            default: begin
                ctl.kind   = K_BAD;
                ctl.unpred = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/msw_arith.sv
module msw_arith
    import msw_pkg::*;
(
    input  ctl_t              ctl,
    input  logic [WORD_W-1:0] srca,
    input  logic [WORD_W-1:0] srcb,
    input  logic [WORD_W-1:0] acc,
    output res_t              res
);

    logic signed [WIDE_W-1:0] ext_a;
    logic signed [WIDE_W-1:0] ext_b;
    logic        [WIDE_W-1:0] prod;
    logic        [WIDE_W-1:0] acc_wide;
    logic        [WIDE_W-1:0] sum;
    logic        [WIDE_W-1:0] rnd_inc;
    logic        [WIDE_W-1:0] rounded;

    assign ext_a    = {{WORD_W{srca[WORD_W-1]}}, srca};
    assign ext_b    = {{WORD_W{srcb[WORD_W-1]}}, srcb};
    assign prod     = ext_a * ext_b;
    assign acc_wide = {acc, {WORD_W{1'b0}}};

    always_comb begin
        unique case (ctl.kind)
            K_ACC:   sum = acc_wide + prod;
            K_SUB:   sum = acc_wide - prod;
            default: sum = prod;
        endcase
    end

    // Adding half an LSB of the high word carries bit WORD_W-1 upward.
    assign rnd_inc = {{WORD_W{1'b0}}, ctl.round, {(WORD_W-1){1'b0}}};
    assign rounded = sum + rnd_inc;

    assign res.unpred = ctl.unpred;
    assign res.word   = ctl.unpred ? '0 : rounded[WIDE_W-1:WORD_W];

endmodule

// File: rtl/msw_pipe.sv
module msw_pipe
    import msw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  res_t d,
    output logic out_valid,
    output res_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            q         <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                q <= d;
            end
        end
    end

    // R9: held output while no result is presented
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(q));

    // R6: an unpredictable result never carries data
    p_unpred_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && q.unpred) |-> (q.word == '0));

endmodule

// File: rtl/msw_mul_unit.sv
module msw_mul_unit
    import msw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic              in_round,
    input  logic [IDX_W-1:0]  in_dst_idx,
    input  logic [IDX_W-1:0]  in_srca_idx,
    input  logic [IDX_W-1:0]  in_srcb_idx,
    input  logic [IDX_W-1:0]  in_acc_idx,
    input  logic [WORD_W-1:0] in_srca,
    input  logic [WORD_W-1:0] in_srcb,
    input  logic [WORD_W-1:0] in_acc,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_unpred
);

    ctl_t ctl;
    res_t comb_res;
    res_t held_res;

    msw_decode u_decode (
        .op       (in_op),
        .round    (in_round),
        .dst_idx  (in_dst_idx),
        .srca_idx (in_srca_idx),
        .srcb_idx (in_srcb_idx),
        .acc_idx  (in_acc_idx),
        .ctl      (ctl)
    );

    msw_arith u_arith (
        .ctl  (ctl),
        .srca (in_srca),
        .srcb (in_srcb),
        .acc  (in_acc),
        .res  (comb_res)
    );

    msw_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .d         (comb_res),
        .out_valid (out_valid),
        .q         (held_res)
    );

    assign out_result = held_res.word;
    assign out_unpred = held_res.unpred;

    // R8: one-cycle latency, valid tracks input valid
    p_valid_lat_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_lat_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6: reserved destination index always reported
    p_dst_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dst_idx == IDX_RESERVED) |=> out_unpred);

    // R7: unknown op codes always reported
    p_bad_op_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != OPC_MULACC && in_op != OPC_MULSUB) |=> (out_unpred && out_result == '0));

    // R2: a zero operand in plain unrounded multiply yields zero
    p_zero_mul_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.kind == K_MUL && !in_round && (in_srca == '0 || in_srcb == '0))
        |=> (out_result == '0));

endmodule

// File: tb/msw_mul_unit_tb.sv
module msw_mul_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = 3'b101;
    logic        in_round = 1'b0;
    logic [3:0]  in_dst_idx = 4'd0;
    logic [3:0]  in_srca_idx = 4'd1;
    logic [3:0]  in_srcb_idx = 4'd2;
    logic [3:0]  in_acc_idx = 4'd3;
    logic [31:0] in_srca = '0;
    logic [31:0] in_srcb = '0;
    logic [31:0] in_acc = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_unpred;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    msw_mul_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_round(in_round),
        .in_dst_idx(in_dst_idx), .in_srca_idx(in_srca_idx), .in_srcb_idx(in_srcb_idx),
        .in_acc_idx(in_acc_idx), .in_srca(in_srca), .in_srcb(in_srcb), .in_acc(in_acc),
        .out_valid(out_valid), .out_result(out_result), .out_unpred(out_unpred)
    );

    function automatic logic exp_unpred(input logic [2:0] op, input logic [3:0] d,
                                        input logic [3:0] n, input logic [3:0] m,
                                        input logic [3:0] a);
        if (op != 3'b101 && op != 3'b110) return 1'b1;
        if (d == 4'hF || n == 4'hF || m == 4'hF) return 1'b1;
        if (op == 3'b110 && a == 4'hF) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_word(input logic [2:0] op, input logic rnd,
                                             input logic [3:0] a_idx, input logic [31:0] x,
                                             input logic [31:0] y, input logic [31:0] acc);
        longint p;
        logic [63:0] s;
        p = longint'($signed(x)) * longint'($signed(y));
        if (op == 3'b101 && a_idx == 4'hF) s = p;
        else if (op == 3'b101) s = {acc, 32'h0} + p;
        else s = {acc, 32'h0} - p;
        if (rnd) s = s + 64'h8000_0000;
        return s[63:32];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic run_op(input string req, input logic [2:0] op, input logic rnd,
                          input logic [3:0] d, input logic [3:0] n, input logic [3:0] m,
                          input logic [3:0] a, input logic [31:0] x, input logic [31:0] y,
                          input logic [31:0] acc);
        logic u;
        logic [31:0] w;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_round = rnd; in_dst_idx = d; in_srca_idx = n;
        in_srcb_idx = m; in_acc_idx = a; in_srca = x; in_srcb = y; in_acc = acc;
        u = exp_unpred(op, d, n, m, a);
        w = u ? 32'h0 : exp_word(op, rnd, a, x, y, acc);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R8 valid"}, {31'h0, out_valid}, 32'h1);
        check({req, " flag"}, {31'h0, out_unpred}, {31'h0, u});
        check({req, " result"}, out_result, w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] keep_r;
        logic        keep_u;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check("R1 valid", {31'h0, out_valid}, 32'h0);
        check("R1 result", out_result, 32'h0);
        check("R1 flag", {31'h0, out_unpred}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {31'h0, out_valid}, 32'h0);

        // R2 extreme pairs, with and without rounding (R5)
        run_op("R2 min*min", 3'b101, 1'b0, 0, 1, 2, 15, 32'h8000_0000, 32'h8000_0000, 0);
        check("R2 min*min value", out_result, 32'h4000_0000);
        run_op("R5 min*min rnd", 3'b101, 1'b1, 0, 1, 2, 15, 32'h8000_0000, 32'h8000_0000, 0);
        run_op("R2 max*min", 3'b101, 1'b0, 0, 1, 2, 15, 32'h7FFF_FFFF, 32'h8000_0000, 0);
        check("R2 max*min value", out_result, 32'hC000_0000);
        run_op("R5 max*min rnd", 3'b101, 1'b1, 0, 1, 2, 15, 32'h7FFF_FFFF, 32'h8000_0000, 0);
        check("R5 max*min rnd value", out_result, 32'hC000_0001);
        // R3 accumulate and R5 wrap to zero
        run_op("R3 acc", 3'b101, 1'b0, 4, 5, 6, 7, 32'h0000_0002, 32'h4000_0000, 32'hFFFF_FFFF);
        check("R3 acc value", out_result, 32'hFFFF_FFFF);
        run_op("R5 wrap", 3'b101, 1'b1, 4, 5, 6, 7, 32'h0000_0002, 32'h4000_0000, 32'hFFFF_FFFF);
        check("R5 wrap value", out_result, 32'h0);
        // R4 subtract
        run_op("R4 sub", 3'b110, 1'b0, 1, 2, 3, 4, 32'h0001_0000, 32'h0001_0000, 32'h5);
        check("R4 sub value", out_result, 32'h4);
        run_op("R4 sub rnd", 3'b110, 1'b1, 1, 2, 3, 4, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_5678);
        // R6 reserved indices
        run_op("R6 dst", 3'b101, 1'b0, 15, 1, 2, 3, 32'h7, 32'h9, 32'h1);
        run_op("R6 srca", 3'b110, 1'b0, 0, 15, 2, 3, 32'h7, 32'h9, 32'h1);
        run_op("R6 srcb", 3'b101, 1'b1, 0, 1, 15, 15, 32'h7, 32'h9, 32'h1);
        run_op("R6 sub acc", 3'b110, 1'b0, 0, 1, 2, 15, 32'h7, 32'h9, 32'h1);
        // R7 unknown op codes
        for (int k = 0; k < 8; k++) begin
            if (k != 5 && k != 6)
                run_op("R7 op", 3'(k), 1'b0, 0, 1, 2, 3, 32'h7, 32'h9, 32'h1);
        end
        // R9 hold while idle
        keep_r = out_result; keep_u = out_unpred;
        @(negedge clk);
        in_op = 3'b101; in_srca = 32'h1234_5678; in_srcb = 32'h7654_3210; in_acc = 32'hAAAA_5555;
        @(negedge clk);
        check("R9 idle valid", {31'h0, out_valid}, 32'h0);
        check("R9 result held", out_result, keep_r);
        check("R9 flag held", {31'h0, out_unpred}, {31'h0, keep_u});

        // Random mix for R2, R3, R4, R5, R6
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            logic [3:0] d, n, m, a;
            op = ($urandom % 2) ? 3'b101 : 3'b110;
            d = ($urandom % 16 == 0) ? 4'hF : 4'($urandom % 15);
            n = ($urandom % 16 == 0) ? 4'hF : 4'($urandom % 15);
            m = ($urandom % 16 == 0) ? 4'hF : 4'($urandom % 15);
            a = ($urandom % 3 == 0) ? 4'hF : 4'($urandom % 15);
            run_op("R2-R6 random", op, 1'($urandom), d, n, m, a, $urandom, $urandom, $urandom);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule